// File: doc/BRIEF.md
# Guarded Halfword Store Unit

This block is the store side of a data-memory path for 16-bit quantities. Each accepted operation carries a base address, a 7-bit signed displacement code, a source word and a guard bit. The block forms the byte address as the base plus twice the sign-extended code, so the reach is -128 to +126 in steps of two. It places the low halfword of the source on a 32-bit byte-enabled write port, and a runtime control bit picks the byte order.

A store to an odd address sets a sticky misalignment flag and is not written. If trapping is enabled at that moment, the block also raises a trap request. The request is held until the control logic acknowledges it at an interruptible jump. A store whose address falls inside a programmable I/O window is also dropped, and it sets its own sticky error flag. A store whose guard is low leaves no trace at all. The write port is registered, so it is driven one cycle after the operation is accepted.

Top module: `hstore_unit`

## Requirements
- R1: The byte address is `op_base + 2*sext(op_disp)`. `wr_addr` carries address bits 31:2. Byte lane k of the port is byte address `wr_addr*4+k`. Address bit 1 = 0 gives `wr_be = 4'b0011`, and address bit 1 = 1 gives `wr_be = 4'b1100`.
- R2: Only `op_src[15:0]` reaches memory and bits 31:16 have no effect. The two-byte pattern appears in both halves of `wr_data`.
- R3: With `big_endian = 1`, the byte at the address gets `op_src[15:8]` and the byte at address+1 gets `op_src[7:0]`.
- R4: With `big_endian = 0`, the byte at the address gets `op_src[7:0]` and the byte at address+1 gets `op_src[15:8]`.
- R5: An operation with `op_guard = 0` causes no write and does not change `mis_flag`, `io_err` or `trap_req`.
- R6: A guarded store to an odd address sets `mis_flag` and produces no write.
- R7: `mis_flag` and `io_err` stay set until `status_clr`. A new event in the same cycle as `status_clr` wins, and the flag stays 1.
- R8: `trap_req` is set by a misaligned store while `trap_en = 1`. It holds until `jump_ack`. A new misaligned store in the cycle of `jump_ack` keeps it set.
- R9: A guarded store whose address satisfies `io_lo <= addr <= io_hi` produces no write and sets `io_err`.
- R10: `wr_valid` is high for exactly the cycle after each accepted, written store, so back-to-back stores give back-to-back strobes. `wr_be` is zero whenever `wr_valid` is low.
- R11: During and after reset, `wr_valid`, `wr_be`, `mis_flag`, `io_err` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Store operation present this cycle |
| op_guard | input | 1 | Guard bit; 0 cancels the store |
| op_base | input | 32 | Base address operand |
| op_disp | input | 7 | Signed displacement code, scaled by 2 |
| op_src | input | 32 | Source operand; low halfword is stored |
| big_endian | input | 1 | Byte order select, 1 = big-endian |
| trap_en | input | 1 | Trap on misaligned store enable |
| status_clr | input | 1 | Clears mis_flag and io_err |
| jump_ack | input | 1 | Interruptible jump taken; clears trap_req |
| io_lo | input | 32 | Lowest byte address of the I/O window |
| io_hi | input | 32 | Highest byte address of the I/O window |
| wr_valid | output | 1 | Write strobe |
| wr_addr | output | 30 | Word address |
| wr_be | output | 4 | Byte enables |
| wr_data | output | 32 | Write data |
| mis_flag | output | 1 | Sticky misaligned-store flag |
| io_err | output | 1 | Sticky I/O-window error flag |
| trap_req | output | 1 | Pending trap request |

## Verification
The bench uses the displacement extremes -128 and +126 to catch a design that drops the sign or forgets the scaling, because either fault sends the bytes to the wrong word or lane. It checks both byte orders against memory contents, so a swapped lane order shows up as reversed bytes. A guard-low store to an odd address is included: a design that lets the guard through only partially would set the misalignment flag there. Set-against-clear collisions on both the flag and the trap request, and addresses at the exact edges of the I/O window, expose wrong priority or off-by-one comparisons.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int BUS_W   = 32;
    localparam int LANES   = BUS_W / 8;
    localparam int HALF_W  = 16;

    typedef struct packed {
        logic [7:0] second;   // byte for address + 1
        logic [7:0] first;    // byte for the effective address
    } byte_pair_t;

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] be;
        logic [BUS_W-1:0] data;
    } wr_beat_t;

    function automatic byte_pair_t order_bytes(input logic [HALF_W-1:0] half,
                                               input logic big);
        byte_pair_t p;
        if (big) begin
            p.first  = half[15:8];
            p.second = half[7:0];
        end else begin
            p.first  = half[7:0];
            p.second = half[15:8];
        end
        return p;
    endfunction

endpackage

// File: rtl/hs_addr_gen.sv
module hs_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 7
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] io_lo,
    input  logic [ADDR_W-1:0] io_hi,
    output logic [ADDR_W-1:0] ea,
    output logic              misal,
    output logic              io_hit
);
    localparam int EXT_W = ADDR_W - DISP_W - 1;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
        ea     = base + offset;
        misal  = ea[0];
        io_hit = (ea >= io_lo) && (ea <= io_hi);
    end
endmodule

// File: rtl/hs_lane_steer.sv
module hs_lane_steer
    import hs_pkg::*;
#(
    parameter int PAIR_IDX_W = $clog2(LANES / 2)
) (
    input  logic [PAIR_IDX_W-1:0] pair_sel,
    input  logic [HALF_W-1:0]     half,
    input  logic                  big,
    output logic [LANES-1:0]      be,
    output logic [BUS_W-1:0]      data
);
    localparam int PAIRS = LANES / 2;

    byte_pair_t pair;

    always_comb pair = order_bytes(half, big);

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign data[g*HALF_W +: HALF_W] = {pair.second, pair.first};
        assign be[2*g +: 2] = (int'(pair_sel) == g) ? 2'b11 : 2'b00;
    end
endmodule

// File: rtl/hs_status.sv
module hs_status (
    input  logic clk,
    input  logic rst,
    input  logic mis_evt,
    input  logic io_evt,
    input  logic trap_en,
    input  logic clr,
    input  logic ack,
    output logic mis_flag,
    output logic io_err,
    output logic trap_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mis_flag <= 1'b0;
            io_err   <= 1'b0;
            trap_req <= 1'b0;
        end else begin
            if (mis_evt)      mis_flag <= 1'b1;
            else if (clr)     mis_flag <= 1'b0;

            if (io_evt)       io_err <= 1'b1;
            else if (clr)     io_err <= 1'b0;

            if (mis_evt && trap_en) trap_req <= 1'b1;
            else if (ack)           trap_req <= 1'b0;
        end
    end
endmodule

// File: rtl/hstore_unit.sv
module hstore_unit
    import hs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_guard,
    input  logic [ADDR_W-1:0] op_base,
    input  logic [DISP_W-1:0] op_disp,
    input  logic [BUS_W-1:0]  op_src,
    input  logic              big_endian,
    input  logic              trap_en,
    input  logic              status_clr,
    input  logic              jump_ack,
    input  logic [ADDR_W-1:0] io_lo,
    input  logic [ADDR_W-1:0] io_hi,
    output logic              wr_valid,
    output logic [ADDR_W-3:0] wr_addr,
    output logic [LANES-1:0]  wr_be,
    output logic [BUS_W-1:0]  wr_data,
    output logic              mis_flag,
    output logic              io_err,
    output logic              trap_req
);
    localparam int LANE_BITS  = $clog2(LANES);
    localparam int PAIR_IDX_W = $clog2(LANES / 2);

    logic [ADDR_W-1:0] ea;
    logic              misal, io_hit, accept, write_ok;
    logic [LANES-1:0]  be_c;
    logic [BUS_W-1:0]  data_c;
    wr_beat_t          beat_q;
    logic [ADDR_W-3:0] addr_q;

    hs_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
        .base   (op_base),
        .disp   (op_disp),
        .io_lo  (io_lo),
        .io_hi  (io_hi),
        .ea     (ea),
        .misal  (misal),
        .io_hit (io_hit)
    );

    hs_lane_steer #(.PAIR_IDX_W(PAIR_IDX_W)) u_steer (
        .pair_sel (ea[LANE_BITS-1:1]),
        .half     (op_src[HALF_W-1:0]),
        .big      (big_endian),
        .be       (be_c),
        .data     (data_c)
    );

    always_comb begin
        accept   = op_valid && op_guard;
        write_ok = accept && !misal && !io_hit;
    end

    hs_status u_status (
        .clk      (clk),
        .rst      (rst),
        .mis_evt  (accept && misal),
        .io_evt   (accept && io_hit),
        .trap_en  (trap_en),
        .clr      (status_clr),
        .ack      (jump_ack),
        .mis_flag (mis_flag),
        .io_err   (io_err),
        .trap_req (trap_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            addr_q <= '0;
        end else begin
            beat_q.valid <= write_ok;
            beat_q.be    <= write_ok ? be_c : '0;
            if (accept) begin
                beat_q.data <= data_c;
                addr_q      <= ea[ADDR_W-1:2];
            end
        end
    end

    assign wr_valid = beat_q.valid;
    assign wr_be    = beat_q.be;
    assign wr_data  = beat_q.data;
    assign wr_addr  = addr_q;
endmodule

// File: rtl/hs_store_chk.sv
module hs_store_chk #(
    parameter int ADDR_W = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic       op_guard,
    input logic [ADDR_W-1:0] op_base,
    input logic       trap_en,
    input logic       status_clr,
    input logic       jump_ack,
    input logic       wr_valid,
    input logic [3:0] wr_be,
    input logic       mis_flag,
    input logic       trap_req
);
    // R1
    be_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_be == 4'b0011 || wr_be == 4'b1100));

    // R10
    be_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (wr_be == 4'b0000));

    // R5
    guard_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_guard) |=> !wr_valid);

    // R5
    guard_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_guard && !status_clr) |=> $stable(mis_flag));

    // R6
    odd_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_guard && op_base[0]) |=> (mis_flag && !wr_valid));

    // R7
    mis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mis_flag && !status_clr) |=> mis_flag);

    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !jump_ack) |=> trap_req);

    // R8
    trap_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_guard && op_base[0] && trap_en) |=> trap_req);
endmodule

bind hstore_unit hs_store_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_guard   (op_guard),
    .op_base    (op_base),
    .trap_en    (trap_en),
    .status_clr (status_clr),
    .jump_ack   (jump_ack),
    .wr_valid   (wr_valid),
    .wr_be      (wr_be),
    .mis_flag   (mis_flag),
    .trap_req   (trap_req)
);

// File: tb/hstore_unit_tb.sv
module hstore_unit_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0, op_guard = 1'b0;
    logic [31:0] op_base = '0;
    logic [6:0]  op_disp = '0;
    logic [31:0] op_src = '0;
    logic        big_endian = 1'b1, trap_en = 1'b0;
    logic        status_clr = 1'b0, jump_ack = 1'b0;
    logic [31:0] io_lo = 32'hFFFF_FFF0, io_hi = 32'hFFFF_FFFF;
    logic        wr_valid;
    logic [29:0] wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic        mis_flag, io_err, trap_req;

    always #(CLK_P/2) clk = ~clk;

    hstore_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_guard(op_guard),
        .op_base(op_base), .op_disp(op_disp), .op_src(op_src),
        .big_endian(big_endian), .trap_en(trap_en), .status_clr(status_clr),
        .jump_ack(jump_ack), .io_lo(io_lo), .io_hi(io_hi),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .mis_flag(mis_flag), .io_err(io_err), .trap_req(trap_req)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R11";

    logic [7:0] mem [logic [31:0]];

    // behavioural reference state
    logic        e_valid = 0, e_mis = 0, e_io = 0, e_trap = 0;
    logic [3:0]  e_be = 0;
    logic [29:0] e_addr = 0;
    logic [31:0] e_data = 0;

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (wr_valid)
            for (int k = 0; k < 4; k++)
                if (wr_be[k]) mem[{wr_addr, 2'b00} + 32'(k)] = wr_data[8*k +: 8];
        if (rst) begin
            e_valid = 0; e_be = 0; e_addr = 0; e_data = 0;
            e_mis = 0; e_io = 0; e_trap = 0;
        end else begin
            logic signed [6:0] sd;
            logic [31:0] ea;
            logic [7:0]  b0, b1;
            bit acc, m, io;
            sd  = op_disp;
            ea  = op_base + 32'(int'(sd) * 2);
            acc = op_valid && op_guard;
            m   = acc && ea[0];
            io  = acc && (ea >= io_lo) && (ea <= io_hi);
            e_valid = acc && !m && !io;
            e_be    = !e_valid ? 4'b0000 : (ea[1] ? 4'b1100 : 4'b0011);
            if (acc) begin
                b0 = big_endian ? op_src[15:8] : op_src[7:0];
                b1 = big_endian ? op_src[7:0]  : op_src[15:8];
                e_addr = ea[31:2];
                e_data = {b1, b0, b1, b0};
            end
            if (m) e_trap = trap_en ? 1'b1 : e_trap;
            else if (jump_ack) e_trap = 0;
            if (!(m && trap_en) && jump_ack) e_trap = 0;
            if (m) e_mis = 1; else if (status_clr) e_mis = 0;
            if (io) e_io = 1; else if (status_clr) e_io = 0;
        end
    end

    always @(negedge clk) begin
        chk(wr_valid == e_valid, tag, "wr_valid", 32'(wr_valid), 32'(e_valid));
        chk(wr_be == e_be, tag, "wr_be", 32'(wr_be), 32'(e_be));
        chk(mis_flag == e_mis, tag, "mis_flag", 32'(mis_flag), 32'(e_mis));
        chk(io_err == e_io, tag, "io_err", 32'(io_err), 32'(e_io));
        chk(trap_req == e_trap, tag, "trap_req", 32'(trap_req), 32'(e_trap));
        if (e_valid) begin
            chk(wr_addr == e_addr, tag, "wr_addr", 32'(wr_addr), 32'(e_addr));
            chk(wr_data == e_data, tag, "wr_data", wr_data, e_data);
        end
    end

    task automatic issue(input logic g, input logic [31:0] b,
                         input logic [6:0] d, input logic [31:0] s);
        @(negedge clk);
        op_valid = 1; op_guard = g; op_base = b; op_disp = d; op_src = s;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            op_valid = 0; op_guard = 0; status_clr = 0; jump_ack = 0;
        end
    endtask

    task automatic mem_is(input logic [31:0] a, input logic [7:0] v, input string t);
        chk(mem.exists(a) && mem[a] == v, t, "mem byte",
            mem.exists(a) ? 32'(mem[a]) : 32'hDEAD, 32'(v));
    endtask

    task automatic mem_none(input logic [31:0] a, input string t);
        chk(!mem.exists(a), t, "unwritten byte", a, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!wr_valid && wr_be == 0 && !mis_flag && !io_err && !trap_req,
            "R11", "reset outputs", {wr_be, wr_valid, mis_flag, io_err, trap_req}, 0);
        rst = 0;
        idle(1);

        // R3 big-endian, R1 positive displacement
        tag = "R3"; big_endian = 1;
        issue(1, 32'h0000_0CFE, 7'h01, 32'h4433_2211); idle(2);
        mem_is(32'hD00, 8'h22, "R3"); mem_is(32'hD01, 8'h11, "R3");

        // R5 guard low on an odd address: nothing at all
        tag = "R5";
        issue(0, 32'h0000_0D05, 7'h7E, 32'hAABB_CCDD); idle(2);
        mem_is(32'hD01, 8'h11, "R5"); mem_none(32'hD02, "R5"); mem_none(32'hD03, "R5");
        chk(!mis_flag, "R5", "mis_flag after guard low", 32'(mis_flag), 0);

        tag = "R3";
        issue(1, 32'h0000_0D06, 7'h7E, 32'hAABB_CCDD); idle(2);
        mem_is(32'hD02, 8'hCC, "R3"); mem_is(32'hD03, 8'hDD, "R3");

        // R4 little-endian, R2 upper bits ignored
        tag = "R4"; big_endian = 0;
        issue(1, 32'h0000_0100, 7'h00, 32'hFFFF_1234); idle(2);
        mem_is(32'h100, 8'h34, "R4"); mem_is(32'h101, 8'h12, "R4");
        tag = "R2";
        issue(1, 32'h0000_0100, 7'h00, 32'h0000_1234); idle(1);
        chk(wr_data == 32'h1234_1234, "R2", "replicated data", wr_data, 32'h1234_1234);
        idle(1);

        // R1 displacement extremes
        tag = "R1"; big_endian = 1;
        issue(1, 32'h0000_1000, 7'h40, 32'h0000_A1B2); idle(2);
        mem_is(32'hF80, 8'hA1, "R1"); mem_is(32'hF81, 8'hB2, "R1");
        issue(1, 32'h0000_1000, 7'h3F, 32'h0000_C3D4); idle(1);
        chk(wr_be == 4'b1100, "R1", "upper lane enables", 32'(wr_be), 32'hC);
        idle(1);
        mem_is(32'h107E, 8'hC3, "R1"); mem_is(32'h107F, 8'hD4, "R1");

        // R10 back-to-back stores
        tag = "R10";
        issue(1, 32'h0000_0200, 7'h00, 32'h0000_0102);
        issue(1, 32'h0000_0202, 7'h00, 32'h0000_0304);
        issue(1, 32'h0000_0204, 7'h00, 32'h0000_0506); idle(2);
        mem_is(32'h203, 8'h04, "R10"); mem_is(32'h204, 8'h05, "R10");

        // R6 misaligned, no trap
        tag = "R6"; trap_en = 0;
        issue(1, 32'h0000_0301, 7'h00, 32'h0000_7777); idle(2);
        mem_none(32'h301, "R6"); mem_none(32'h302, "R6");
        chk(mis_flag && !trap_req, "R6", "flag without trap",
            {mis_flag, trap_req}, 32'h2);

        // R7 sticky, clear, set wins over clear
        tag = "R7";
        issue(1, 32'h0000_0310, 7'h00, 32'h0); idle(2);
        chk(mis_flag, "R7", "sticky", 32'(mis_flag), 1);
        @(negedge clk); status_clr = 1; idle(1);
        chk(!mis_flag, "R7", "cleared", 32'(mis_flag), 0);
        issue(1, 32'h0000_0303, 7'h00, 32'h0); status_clr = 1; idle(1);
        chk(mis_flag, "R7", "set beats clear", 32'(mis_flag), 1);
        @(negedge clk); status_clr = 1; idle(1);

        // R8 trap hold, ack, raise beats ack
        tag = "R8"; trap_en = 1;
        issue(1, 32'h0000_0305, 7'h00, 32'h0); idle(4);
        chk(trap_req, "R8", "trap held", 32'(trap_req), 1);
        @(negedge clk); jump_ack = 1; idle(1);
        chk(!trap_req, "R8", "trap acked", 32'(trap_req), 0);
        issue(1, 32'h0000_0307, 7'h00, 32'h0); jump_ack = 1; idle(1);
        chk(trap_req, "R8", "raise beats ack", 32'(trap_req), 1);
        @(negedge clk); jump_ack = 1; status_clr = 1; idle(1);
        trap_en = 0;

        // R9 I/O window edges
        tag = "R9"; io_lo = 32'h0000_2000; io_hi = 32'h0000_20FF;
        issue(1, 32'h0000_2000, 7'h00, 32'h0000_5566); idle(2);
        mem_none(32'h2000, "R9");
        chk(io_err, "R9", "io_err set", 32'(io_err), 1);
        issue(1, 32'h0000_20FE, 7'h00, 32'h0000_5566); idle(2);
        mem_none(32'h20FE, "R9");
        issue(1, 32'h0000_2100, 7'h00, 32'h0000_5566); idle(2);
        mem_is(32'h2100, 8'h55, "R9");
        issue(1, 32'h0000_1FFE, 7'h00, 32'h0000_5566); idle(2);
        mem_is(32'h1FFF, 8'h66, "R9");
        tag = "R7";
        @(negedge clk); status_clr = 1; idle(2);
        chk(!io_err, "R7", "io_err cleared", 32'(io_err), 0);

        finish_run();
    end
endmodule